// File: doc/BRIEF.md
# Parallel Multi-Pattern Serial Bit Detector

This block watches a serial bit stream, qualified by a valid strobe, and searches it for several fixed bit patterns at once. Each pattern has its own progress tracker, which counts how many leading bits of that pattern have matched so far. A registered hit vector carries one bit per pattern. It pulses for one cycle after the bit that completes that pattern has been accepted.

The restart rule is kept simple on purpose. A mismatch drops the tracker to zero, and the mismatching bit is not tried again as a first bit. A completed match also restarts the tracker at zero, so matches never overlap. The patterns and their lengths are fixed when the design is built. Any number of patterns may complete on the same bit, and every one of them is reported.

Top module: `multi_pattern_detector`

## Requirements
- R1: Pattern `i` sits right-aligned in bits `[i*MAX_LEN +: MAX_LEN]` of `PATTERNS`, and its length (2 to `MAX_LEN`, with `MAX_LEN` at most 16) sits in `[i*LEN_W +: LEN_W]` of `LENS`. Pattern bits are compared most significant first, in stream order. By default pattern 0 is `101` and pattern 1 is `110`, and hit bit `i` belongs to pattern `i`.
- R2: Tracking state changes only on clock edges where `bitValid` is high. A cycle with `bitValid` low leaves every tracker unchanged and produces no hit.
- R3: An accepted bit that equals the expected pattern bit advances that pattern's progress by one. When progress reaches the pattern length, hit bit `i` is high in the cycle after the completing bit's clock edge, and only in that cycle.
- R4: An accepted bit that differs from the expected bit returns that pattern's progress to zero. The mismatching bit is not re-checked as a first pattern bit. For example, with `110` the stream `1110` produces no hit.
- R5: After a hit, that pattern's progress restarts at zero, so matches do not overlap. With `101` the stream `10101` gives exactly one hit, on the third bit.
- R6: Every pattern that completes on the same accepted bit raises its hit bit in the same cycle.
- R7: A synchronous active-high `rst` clears every progress counter and the hit vector, and it overrides `bitValid`.
- R8: With the default patterns, the stream `110101110` gives a hit for `110` on bit 3 and a hit for `101` on bit 6, and no other hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Qualifies `bitIn` on this edge |
| bitIn | input | 1 | Serial data bit |
| hitVec | output | NUM_PAT | Registered one-cycle hit per pattern |

## Verification
A bit presented with `bitValid` is taken at one rising edge. Its hit appears on `hitVec` right after that same edge, so the result is due one cycle after the stimulus and is gone after one more. The bench drives each bit on a falling edge and lets exactly one rising edge pass. It then compares `hitVec` at the next falling edge with a stream model that applies the same restart rules. Because every bit is checked, each pulse is checked in its own cycle, and a stretched pulse or a late pulse shows up as a miscompare.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  // Strobes from control to the per-pattern trackers.
  typedef struct packed {
    logic clear;   // synchronous clear of all tracking state
    logic accept;  // consume bitIn on this edge
  } trackCtrl_t;

endpackage

// File: rtl/mpd_ctrl.sv
module mpd_ctrl
  import mpd_pkg::*;
(
  input  logic       rst,
  input  logic       bitValid,
  output trackCtrl_t ctrl
);

  // Reset has priority over an incoming bit.
  always_comb begin
    ctrl.clear  = rst;
    ctrl.accept = bitValid && !rst;
  end

endmodule

// File: rtl/mpd_track.sv
module mpd_track
  import mpd_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int CNT_W   = 4,
  parameter int LEN     = 3,
  parameter logic [MAX_LEN-1:0] PAT = '0
) (
  input  logic             clk,
  input  trackCtrl_t       ctrl,
  input  logic             bitIn,
  output logic [CNT_W-1:0] progress,
  output logic             hit
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] bitIdx;
  logic             expBit;
  logic             match;
  logic             atLast;

  // Most significant pattern bit comes first in the stream.
  always_comb begin
    bitIdx = LAST_POS - progress;
    expBit = PAT[bitIdx];
    match  = (bitIn == expBit);
    atLast = (progress == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      progress <= '0;
      hit      <= 1'b0;
    end else if (ctrl.accept) begin
      if (match && atLast) begin
        progress <= '0;
        hit      <= 1'b1;
      end else if (match) begin
        progress <= progress + 1'b1;
        hit      <= 1'b0;
      end else begin
        progress <= '0;
        hit      <= 1'b0;
      end
    end else begin
      hit <= 1'b0;
    end
  end

endmodule

// File: rtl/multi_pattern_detector.sv
module multi_pattern_detector
  import mpd_pkg::*;
#(
  parameter int NUM_PAT = 2,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter logic [NUM_PAT*MAX_LEN-1:0] PATTERNS = {16'b110, 16'b101},
  parameter logic [NUM_PAT*LEN_W-1:0]   LENS     = {5'd3, 5'd3}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bitValid,
  input  logic               bitIn,
  output logic [NUM_PAT-1:0] hitVec
);

  localparam int CNT_W = $clog2(MAX_LEN);

  trackCtrl_t               ctrl;
  logic [NUM_PAT*CNT_W-1:0] progressVec;

  mpd_ctrl u_ctrl (
    .rst      (rst),
    .bitValid (bitValid),
    .ctrl     (ctrl)
  );

  for (genvar gi = 0; gi < NUM_PAT; gi++) begin : g_track
    localparam int THIS_LEN = int'(LENS[gi*LEN_W +: LEN_W]);
    localparam logic [MAX_LEN-1:0] THIS_PAT = PATTERNS[gi*MAX_LEN +: MAX_LEN];

    mpd_track #(
      .MAX_LEN (MAX_LEN),
      .CNT_W   (CNT_W),
      .LEN     (THIS_LEN),
      .PAT     (THIS_PAT)
    ) u_track (
      .clk      (clk),
      .ctrl     (ctrl),
      .bitIn    (bitIn),
      .progress (progressVec[gi*CNT_W +: CNT_W]),
      .hit      (hitVec[gi])
    );
  end

endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
  parameter int NUM_PAT = 2,
  parameter int CNT_W   = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bitValid,
  input logic [NUM_PAT-1:0]       hitVec,
  input logic [NUM_PAT*CNT_W-1:0] progressVec
);

  // R7: reset clears everything on the following cycle
  a_r7_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (hitVec == '0 && progressVec == '0));

  // R2: an idle cycle leaves tracking state untouched
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!bitValid && !$past(rst)) |=> $stable(progressVec));

  for (genvar gi = 0; gi < NUM_PAT; gi++) begin : g_chk
    // R3: a hit lasts exactly one cycle
    a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (rst)
      hitVec[gi] |=> !hitVec[gi]);

    // R2: a hit needs an accepted bit on the previous edge
    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
      hitVec[gi] |-> $past(bitValid));

    // R5: progress restarts at zero with the hit
    a_r5_restart_after_hit: assert property (@(posedge clk) disable iff (rst)
      hitVec[gi] |-> (progressVec[gi*CNT_W +: CNT_W] == '0));
  end

endmodule

bind multi_pattern_detector mpd_checker #(
  .NUM_PAT (NUM_PAT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bitValid    (bitValid),
  .hitVec      (hitVec),
  .progressVec (progressVec)
);

// File: tb/multi_pattern_detector_bench.sv
module multi_pattern_detector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 16;
  localparam logic [MAXL-1:0] PAT0 = 16'b101;
  localparam int LEN0 = 3;
  localparam logic [MAXL-1:0] PAT1 = 16'b110;
  localparam int LEN1 = 3;

  logic clk = 1'b0;
  logic rst;
  logic bitValid;
  logic bitIn;
  logic [1:0] hitVec;
  logic [1:0] hitPair;

  int vectors = 0;
  int fails = 0;
  int prog0 = 0;
  int prog1 = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_pattern_detector u_multi_pattern_detector (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn), .hitVec(hitVec)
  );

  // Second build: pattern 0 = 11 (len 2), pattern 1 = 011 (len 3)
  multi_pattern_detector #(
    .PATTERNS ({16'b011, 16'b11}),
    .LENS     ({5'd3, 5'd2})
  ) u_multi_pattern_detector_pair (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn), .hitVec(hitPair)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic b, input logic v, output logic [1:0] exp);
    exp = 2'b00;
    if (v) begin
      if (b == PAT0[LEN0-1-prog0]) begin
        if (prog0 + 1 == LEN0) begin exp[0] = 1'b1; prog0 = 0; end
        else prog0++;
      end else prog0 = 0;
      if (b == PAT1[LEN1-1-prog1]) begin
        if (prog1 + 1 == LEN1) begin exp[1] = 1'b1; prog1 = 0; end
        else prog1++;
      end else prog1 = 0;
    end
  endtask

  // Drive at falling edge, one rising edge, compare at the next falling edge.
  task automatic drive(input string req, input logic b, input logic v);
    logic [1:0] exp;
    bitIn = b; bitValid = v;
    model_step(b, v, exp);
    @(posedge clk);
    @(negedge clk);
    check(req, hitVec, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1; bitValid = 1'b0; bitIn = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    prog0 = 0; prog1 = 0;
  endtask

  task automatic drive_str(input string req, input string s);
    for (int k = 0; k < s.len(); k++) drive(req, s[k] == "1", 1'b1);
  endtask

  task automatic test_reset_state();
    do_reset();
    check("R7 reset state", hitVec, 2'b00);
    check("R7 reset state pair", hitPair, 2'b00);
  endtask

  task automatic test_example();
    do_reset();
    drive_str("R8 example stream / R1 order", "110101110");
  endtask

  task automatic test_mismatch();
    do_reset();
    drive_str("R4 mismatch drops to zero", "1110");
    drive_str("R4 no recheck of mismatching bit", "100101");
  endtask

  task automatic test_no_overlap();
    do_reset();
    drive_str("R5 no overlap", "10101");
    drive_str("R5 restart after hit", "0101");
  endtask

  task automatic test_valid_gating();
    do_reset();
    drive("R2 gated", 1'b1, 1'b1);
    drive("R2 gated idle", 1'b0, 1'b0);
    drive("R2 gated idle", 1'b1, 1'b0);
    drive("R2 gated", 1'b1, 1'b1);
    drive("R2 gated idle", 1'b0, 1'b0);
    drive("R2 gated completes 110", 1'b0, 1'b1);
  endtask

  task automatic test_simultaneous();
    do_reset();
    bitValid = 1'b1;
    bitIn = 1'b0; @(posedge clk); @(negedge clk);
    check("R6 pair after 0", hitPair, 2'b00);
    bitIn = 1'b1; @(posedge clk); @(negedge clk);
    check("R6 pair after 01", hitPair, 2'b00);
    bitIn = 1'b1; @(posedge clk); @(negedge clk);
    check("R6 simultaneous hits", hitPair, 2'b11);
    bitValid = 1'b0; @(posedge clk); @(negedge clk);
    check("R3 pair pulse one cycle", hitPair, 2'b00);
  endtask

  task automatic test_mid_reset();
    do_reset();
    drive_str("R7 prefix", "11");
    rst = 1'b1; bitValid = 1'b1; bitIn = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 reset overrides valid", hitVec, 2'b00);
    rst = 1'b0; prog0 = 0; prog1 = 0;
    drive("R7 progress cleared", 1'b0, 1'b1);
  endtask

  task automatic test_random();
    do_reset();
    for (int n = 0; n < 4000; n++)
      drive("R3 random stream", 1'($urandom), ($urandom % 4) != 0);
    drive("R3 pulse drains", 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; bitValid = 1'b0; bitIn = 1'b0;
    @(negedge clk);
    test_reset_state();
    test_example();
    test_mismatch();
    test_no_overlap();
    test_valid_gating();
    test_simultaneous();
    test_mid_reset();
    test_random();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule